// File: doc/BRIEF.md
# Segmented Acquisition Storage Controller

This block steers a stream of sample words into a large external memory as a run of short records, each one started by a trigger. After being armed it waits for a trigger. Each accepted trigger opens the next record, called a segment. The incoming sample words are packed into wider memory words and written at consecutive addresses. Segment n begins at `cfg_base + n * cfg_seg_len`. For each accepted trigger the block emits one entry on a table write port: the segment number, the segment's start address, the trigger position inside the sample word, and a timestamp counted in clock cycles since arming.

Once a segment is full, the block spends a fixed, short re-arm interval and then waits for the next trigger. A trigger that arrives while a segment is filling or re-arming is not used and is counted instead. The memory port uses a valid/ready handshake. A small FIFO sits between the packer and the port. When the FIFO is full, the block lowers `s_ready` while a segment is filling, so no sample is lost or repeated when the memory stalls. When the programmed number of segments has been captured and the FIFO has drained, the block raises `done` and writes nothing more. `abort` returns the block to idle from any state.

The controller has six states, joined by these transitions:

| From | Transition | To |
| --- | --- | --- |
| IDLE | arm | WAIT |
| WAIT | trigger accepted | FILL |
| FILL | segment full, not the last segment | REARM |
| FILL | last segment full | DRAIN |
| REARM | re-arm interval elapsed | WAIT |
| DRAIN | FIFO empty | DONE |
| DONE | arm | WAIT |
| any state | abort | IDLE |

Top module: `seg_acq_ctrl`

## Requirements
- R1: After reset the block is idle, with `done`=0, `m_valid`=0, `tbl_we`=0, `missed_cnt`=0 and `s_ready`=1.
- R2: `arm` is taken only in IDLE or DONE. Taking it clears `done`, the missed-trigger count, the segment number and the timestamp, and it sets the write address to `cfg_base`.
- R3: A trigger taken in WAIT raises `tbl_we` for one cycle after the sampling edge. The entry carries the segment number, the start address `cfg_base + n*cfg_seg_len`, `trig_pos`, and a timestamp. The timestamp is the number of clock edges from the edge that took `arm` to the edge that took the trigger, minus one.
- R4: Width conversion packs MEM_W/IN_W accepted input words into one memory word, with the first word in the lowest bits. Memory words are written to consecutive addresses, starting at the segment start.
- R5: Each segment holds exactly `cfg_seg_len` memory words. The following segment begins at the next address.
- R6: Outside FILL, `s_ready` is 1 and input words are accepted and discarded.
- R7: A trigger in FILL or REARM creates no table entry and adds one to `missed_cnt`, which saturates at its maximum. This holds even when the trigger falls in the cycle that takes the segment's final input word.
- R8: Re-arm lasts exactly REARM_CYC cycles. With L the edge that takes a segment's final input word, a trigger sampled at edge L+REARM_CYC is missed and one sampled at L+REARM_CYC+1 is taken.
- R9: While `m_valid`=1 and `m_ready`=0, `m_addr` and `m_data` hold steady. In FILL, `s_ready` drops while the FIFO is full. No word is lost or duplicated.
- R10: After `cfg_last_seg`+1 segments, and once the FIFO is empty, `done` rises. From then on there are no memory writes and no table writes, and triggers are not counted.
- R11: `abort` forces IDLE from any state on the next edge and drops the FIFO contents, so `m_valid`=0 and `done`=0 afterwards. Triggers in IDLE are neither recorded nor counted.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Start an acquisition |
| abort | input | 1 | Return to idle and drop buffered data |
| cfg_base | input | ADDR_W | Address of segment 0 |
| cfg_seg_len | input | LEN_W | Memory words per segment (at least 1) |
| cfg_last_seg | input | SEG_W | Number of segments minus one |
| trig | input | 1 | Trigger event from the comparators |
| trig_pos | input | POS_W | Trigger position inside the current sample word |
| s_valid | input | 1 | Input sample word valid |
| s_data | input | IN_W | Input sample word |
| s_ready | output | 1 | Input word can be taken |
| m_valid | output | 1 | Memory write request |
| m_addr | output | ADDR_W | Memory word address |
| m_data | output | MEM_W | Memory write data |
| m_ready | input | 1 | Memory takes the write |
| tbl_we | output | 1 | Segment table entry strobe |
| tbl_idx | output | SEG_W | Segment number of the entry |
| tbl_start | output | ADDR_W | Start address of the segment |
| tbl_pos | output | POS_W | Captured trigger position |
| tbl_stamp | output | TS_W | Timestamp in cycles since arm |
| done | output | 1 | All segments captured and written |
| missed_cnt | output | CNT_W | Triggers that arrived while busy |

## Verification
Two functions can fall in the same cycle: a segment completing on its final input word, and a trigger arriving. The bench provokes this in two ways. First, it asserts the trigger together with the segment's final input word. Second, it holds a trigger for two cycles so that it spans the last REARM cycle and the first WAIT cycle. The verdict comes from the missed-trigger count, read at the ports, and from a scoreboard of expected table entries. The scoreboard must see exactly one entry, carrying the right segment number and timestamp. Memory writes are compared against a queue of expected address/data pairs, both under a held-low `m_ready` and under an alternating one.

// File: rtl/seg_acq_pkg.sv
package seg_acq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FILL,
        ST_REARM,
        ST_DRAIN,
        ST_DONE
    } acq_state_e;
endpackage

// File: rtl/seg_acq_fifo.sv
module seg_acq_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + PW'(1);
            if (pop_ok)  rp <= rp + PW'(1);
            cnt <= cnt + {{PW{1'b0}}, push_ok} - {{PW{1'b0}}, pop_ok};
        end
    end
endmodule

// File: rtl/seg_acq_packer.sv
module seg_acq_packer #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int RATIO = OUT_W / IN_W;
    localparam int CW    = (RATIO > 2) ? $clog2(RATIO) : 1;

    logic [CW-1:0]   cnt;
    logic [IN_W-1:0] hold [RATIO-1];
    logic            last;

    assign last      = (cnt == CW'(RATIO-1));
    assign out_valid = in_valid && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (in_valid) begin
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end

    for (genvar i = 0; i < RATIO-1; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (in_valid && cnt == CW'(i)) begin
                hold[i] <= in_data;
            end
        end
        assign out_data[i*IN_W +: IN_W] = hold[i];
    end
    assign out_data[OUT_W-1 -: IN_W] = in_data;
endmodule

// File: rtl/seg_acq_addr.sv
module seg_acq_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              seg_end,
    input  logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] seg_start
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr   <= '0;
            seg_start <= '0;
        end else if (load) begin
            wr_addr   <= base;
            seg_start <= base;
        end else begin
            if (wr_fire) wr_addr   <= wr_addr + ADDR_W'(1);
            if (seg_end) seg_start <= seg_start + ADDR_W'(len);
        end
    end
endmodule

// File: rtl/seg_acq_ctrl.sv
module seg_acq_ctrl
    import seg_acq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IN_W       = 32,
    parameter int MEM_W      = 64,
    parameter int LEN_W      = 16,
    parameter int SEG_W      = 16,
    parameter int POS_W      = 4,
    parameter int TS_W       = 32,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int REARM_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              abort,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_seg_len,
    input  logic [SEG_W-1:0]  cfg_last_seg,
    input  logic              trig,
    input  logic [POS_W-1:0]  trig_pos,
    input  logic              s_valid,
    input  logic [IN_W-1:0]   s_data,
    output logic              s_ready,
    output logic              m_valid,
    output logic [ADDR_W-1:0] m_addr,
    output logic [MEM_W-1:0]  m_data,
    input  logic              m_ready,
    output logic              tbl_we,
    output logic [SEG_W-1:0]  tbl_idx,
    output logic [ADDR_W-1:0] tbl_start,
    output logic [POS_W-1:0]  tbl_pos,
    output logic [TS_W-1:0]   tbl_stamp,
    output logic              done,
    output logic [CNT_W-1:0]  missed_cnt
);
    localparam int RC_W = $clog2(REARM_CYC + 1);

    acq_state_e        state, nxt;
    logic [LEN_W-1:0]  fill_cnt;
    logic [SEG_W-1:0]  seg_idx;
    logic [RC_W-1:0]   rearm_cnt;
    logic [TS_W-1:0]   stamp;
    logic [ADDR_W-1:0] seg_start;
    logic              start_ok, trig_take, trig_miss, samp_take;
    logic              pk_valid, fill_last, seg_last, rearm_done;
    logic [MEM_W-1:0]  pk_data;
    logic              fifo_empty, fifo_full, wr_fire, flush;

    assign start_ok   = arm && (state == ST_IDLE || state == ST_DONE);
    assign trig_take  = trig && (state == ST_WAIT);
    assign trig_miss  = trig && (state == ST_FILL || state == ST_REARM);
    assign samp_take  = s_valid && s_ready && (state == ST_FILL);
    assign fill_last  = pk_valid && (fill_cnt == cfg_seg_len - LEN_W'(1));
    assign seg_last   = (seg_idx == cfg_last_seg);
    assign rearm_done = (rearm_cnt == RC_W'(REARM_CYC - 1));
    assign flush      = abort || start_ok;
    assign wr_fire    = m_valid && m_ready;

    seg_acq_packer #(.IN_W(IN_W), .OUT_W(MEM_W)) packer_i (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .in_valid(samp_take), .in_data(s_data),
        .out_valid(pk_valid), .out_data(pk_data)
    );

    seg_acq_fifo #(.W(MEM_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(pk_valid), .din(pk_data),
        .pop(wr_fire), .dout(m_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    seg_acq_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) addr_i (
        .clk(clk), .rst_n(rst_n), .load(start_ok),
        .base(cfg_base), .len(cfg_seg_len),
        .seg_end(fill_last), .wr_fire(wr_fire),
        .wr_addr(m_addr), .seg_start(seg_start)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_ok)   nxt = ST_WAIT;
            ST_WAIT:  if (trig)       nxt = ST_FILL;
            ST_FILL:  if (fill_last)  nxt = seg_last ? ST_DRAIN : ST_REARM;
            ST_REARM: if (rearm_done) nxt = ST_WAIT;
            ST_DRAIN: if (fifo_empty) nxt = ST_DONE;
            ST_DONE:  if (start_ok)   nxt = ST_WAIT;
            default:                  nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    // State-decoded outputs
    always_comb begin
        done    = (state == ST_DONE);
        s_ready = (state != ST_FILL) || !fifo_full;
        m_valid = !fifo_empty;
    end

    // Counters and table capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt   <= '0;
            seg_idx    <= '0;
            rearm_cnt  <= '0;
            stamp      <= '0;
            missed_cnt <= '0;
            tbl_we     <= 1'b0;
            tbl_idx    <= '0;
            tbl_start  <= '0;
            tbl_pos    <= '0;
            tbl_stamp  <= '0;
        end else begin
            stamp     <= start_ok ? '0 : stamp + TS_W'(1);
            rearm_cnt <= (state == ST_REARM) ? rearm_cnt + RC_W'(1) : '0;
            tbl_we    <= trig_take && !abort;
            if (trig_take) begin
                tbl_idx   <= seg_idx;
                tbl_start <= seg_start;
                tbl_pos   <= trig_pos;
                tbl_stamp <= stamp;
            end
            if (start_ok) begin
                fill_cnt   <= '0;
                seg_idx    <= '0;
                missed_cnt <= '0;
            end else begin
                if (abort) fill_cnt <= '0;
                else if (pk_valid) fill_cnt <= fill_last ? '0 : fill_cnt + LEN_W'(1);
                if (fill_last) seg_idx <= seg_idx + SEG_W'(1);
                if (trig_miss && missed_cnt != '1) missed_cnt <= missed_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/seg_acq_chk.sv
module seg_acq_chk
    import seg_acq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MEM_W  = 64,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              abort,
    input logic              trig,
    input logic              m_valid,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic [MEM_W-1:0]  m_data,
    input logic              tbl_we,
    input logic              done,
    input logic [CNT_W-1:0]  missed_cnt,
    input acq_state_e        state
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !abort) |=> (m_valid && $stable(m_addr) && $stable(m_data)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !arm && !abort) |=> (m_addr == $past(m_addr) + ADDR_W'(1)));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!m_valid && !tbl_we));

    // R7
    miss_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (state == ST_FILL || state == ST_REARM)) |=> !tbl_we);

    // R7
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + CNT_W'(1)));

    // R3
    entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> ($past(trig) && $past(state) == ST_WAIT));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_IDLE && !m_valid && !done));
endmodule

bind seg_acq_ctrl seg_acq_chk #(.ADDR_W(ADDR_W), .MEM_W(MEM_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .trig(trig),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
    .tbl_we(tbl_we), .done(done), .missed_cnt(missed_cnt), .state(state)
);

// File: tb/seg_acq_ctrl_tb_top.sv
module seg_acq_ctrl_tb_top;
    localparam int AW = 32, IW = 32, MW = 64, RC = 2, LEN = 4;

    logic          clk = 0, rst_n = 0, arm = 0, abort = 0, trig = 0;
    logic [AW-1:0] cfg_base = 32'h1000;
    logic [15:0]   cfg_seg_len = 16'(LEN), cfg_last_seg = 16'd2;
    logic [3:0]    trig_pos = 0;
    logic          s_valid = 0, s_ready, m_valid, m_ready = 0, tbl_we, done;
    logic [IW-1:0] s_data = 0;
    logic [AW-1:0] m_addr, tbl_start;
    logic [MW-1:0] m_data;
    logic [15:0]   tbl_idx, missed_cnt;
    logic [3:0]    tbl_pos;
    logic [31:0]   tbl_stamp;

    seg_acq_ctrl #(.FIFO_DEPTH(2), .REARM_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
        .cfg_base(cfg_base), .cfg_seg_len(cfg_seg_len), .cfg_last_seg(cfg_last_seg),
        .trig(trig), .trig_pos(trig_pos), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data),
        .m_ready(m_ready), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_start(tbl_start),
        .tbl_pos(tbl_pos), .tbl_stamp(tbl_stamp), .done(done), .missed_cnt(missed_cnt)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, arm_cyc = 0;
    int stall_mode = 0, seg_n = 0, jw = 0, wv = 1;
    bit filling = 0, half = 0, tog = 0, finished = 0;
    logic [IW-1:0] lo;
    logic [AW+MW-1:0] exp_mem[$];
    logic [83:0]      exp_tbl[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: drives m_ready, pops scoreboards on every transfer
    always @(negedge clk) begin
        tog = ~tog;
        m_ready = (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? tog : 1'b0;
        #1;
        if (rst_n && m_valid && m_ready) begin
            if (exp_mem.size() == 0) chk("R6/R10 unexpected memory write", {m_addr, m_data}, 0);
            else chk("R4/R5 memory write", {m_addr, m_data}, exp_mem.pop_front());
        end
        if (rst_n && tbl_we) begin
            if (exp_tbl.size() == 0) chk("R7/R11 unexpected table entry", {tbl_idx, tbl_start, tbl_pos, tbl_stamp}, 0);
            else chk("R3 table entry", {tbl_idx, tbl_start, tbl_pos, tbl_stamp}, exp_tbl.pop_front());
        end
    end

    function automatic logic [83:0] tbl_item(input int pos);
        return {16'(seg_n), cfg_base + 32'(seg_n * LEN), 4'(pos), 32'(cyc - arm_cyc - 1)};
    endfunction

    task automatic do_arm();
        @(negedge clk) arm = 1;
        @(negedge clk) arm = 0;
        arm_cyc = cyc; seg_n = 0; filling = 0;
    endtask

    task automatic fire_trig(input int pos, input bit accept);
        @(negedge clk) begin trig = 1; trig_pos = 4'(pos); end
        @(negedge clk) trig = 0;
        if (accept) begin exp_tbl.push_back(tbl_item(pos)); filling = 1; jw = 0; half = 0; end
    endtask

    task automatic send_words(input int n, input bit trig_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1; s_data = 32'(wv); trig = trig_last && (i == n-1);
            #2;
            while (!s_ready) begin @(negedge clk); #2; end
            if (filling) begin
                if (!half) begin lo = 32'(wv); half = 1; end
                else begin
                    exp_mem.push_back({cfg_base + 32'(seg_n * LEN + jw), 32'(wv), lo});
                    half = 0; jw++;
                    if (jw == LEN) begin filling = 0; seg_n++; jw = 0; end
                end
            end
            wv++;
        end
        @(negedge clk) begin s_valid = 0; trig = 0; end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 60 && !done; k++) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 done", done, 0);
        chk("R1 m_valid", m_valid, 0);
        chk("R1 tbl_we", tbl_we, 0);
        chk("R1 missed_cnt", missed_cnt, 0);
        chk("R1 s_ready", s_ready, 1);

        // Idle: words and trigger ignored
        send_words(2, 0);
        fire_trig(1, 0);
        #1 chk("R11 idle trigger not counted", missed_cnt, 0);

        do_arm();
        send_words(3, 0);
        #1 chk("R6 s_ready while waiting", s_ready, 1);

        // Segment 0 with memory stalled
        fire_trig(3, 1);
        stall_mode = 2;
        send_words(4, 0);
        #2 chk("R9 s_ready low when FIFO full", s_ready, 0);
        chk("R9 m_valid held under stall", m_valid, 1);
        fire_trig(2, 0);
        #1 chk("R7 trigger during fill counted", missed_cnt, 1);
        stall_mode = 0;
        send_words(4, 0);
        // R8: two-cycle trigger spanning last REARM cycle and first WAIT cycle
        @(negedge clk) begin trig = 1; trig_pos = 4'd6; end
        @(negedge clk);
        @(negedge clk) trig = 0;
        exp_tbl.push_back(tbl_item(6)); filling = 1; jw = 0; half = 0;
        #1 chk("R8 rearm boundary trigger missed once", missed_cnt, 2);

        // Segment 1: trigger together with final word
        send_words(8, 1);
        repeat (4) @(negedge clk);
        #1 chk("R7 trigger with final word counted", missed_cnt, 3);

        // Segment 2 (last) with alternating memory ready
        stall_mode = 1;
        fire_trig(9, 1);
        send_words(8, 0);
        wait_done();
        chk("R10 done after last segment", done, 1);
        chk("R10 no write after done", m_valid, 0);
        chk("R5 every segment word written", exp_mem.size(), 0);
        fire_trig(4, 0);
        send_words(2, 0);
        #1 chk("R10 trigger after done not counted", missed_cnt, 3);

        // Re-arm from DONE, then abort mid-segment
        stall_mode = 2;
        do_arm();
        #1 chk("R2 done cleared by arm", done, 0);
        chk("R2 missed count cleared by arm", missed_cnt, 0);
        fire_trig(5, 1);
        send_words(4, 0);
        @(negedge clk) begin abort = 1; exp_mem.delete(); end
        @(negedge clk) abort = 0;
        filling = 0; stall_mode = 0;
        #1 chk("R11 m_valid low after abort", m_valid, 0);
        chk("R11 done low after abort", done, 0);
        send_words(2, 0);

        // Single-segment acquisition after abort restarts at base
        cfg_last_seg = 16'd0;
        do_arm();
        fire_trig(7, 1);
        send_words(8, 0);
        wait_done();
        chk("R2 single segment done", done, 1);
        chk("R5 all words written after rearm", exp_mem.size(), 0);
        chk("R3 all table entries seen", exp_tbl.size(), 0);

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule